// File: doc/BRIEF.md
# Interrupt controller command decoder

This block is the programming front end of one eight-input legacy interrupt controller. It sits on a byte-wide strobe bus that has a single address bit. It walks the four-step initialization handshake and holds the resulting configuration: the vector base, auto end-of-interrupt, special fully nested operation and CPU-mode check. Once initialized, it decodes the three operation commands. These cover the mask load, end-of-interrupt with optional priority rotation, special mask mode, read-register selection and polling. It drives the configuration state out as plain outputs. End-of-interrupt clears, request-register clears and poll acknowledges go out as single-cycle strobes.

The priority search lives outside the block. It supplies the highest eligible request pin and the highest in-service pin as inputs. The request and in-service registers also live outside and come back in for reads. A read strobe returns data combinationally in the same cycle. A poll read acknowledges the winning pin in that cycle. Bus accesses last one cycle each, and there is no back-pressure: every strobe is consumed in the cycle it is high. A cycle with both strobes high is treated as a write, and the read is dropped.

Top module: `intc_cmd_decoder`

## Requirements
- R1: A write with address bit 0 and data bit 4 set starts initialization. It pulses `irr_clr` in that cycle. From the next cycle the mask is 0, the lowest-priority pointer is 7, and read-select, poll, special mask and `ready` are all 0.
- R2: The start word is valid only with data bit 1 clear and data bit 0 set. Otherwise `init_err` pulses in the write cycle, no sequence follows, and later address-1 writes leave the mask at 0 and `ready` at 0.
- R3: After a valid start word, the next three address-1 writes are steps 2, 3 and 4. Step 2 loads data bits 7:3 into `vec_base`. Step 3 changes no output.
- R4: Step 4 with data bit 0 clear pulses `init_err` and leaves `ready` low. With bit 0 set, it loads `aeoi_en` from bit 1, loads `sfn_en` from bit 4 (master instance only) and raises `ready`.
- R5: While `ready` is high, an address-1 write loads the 8-bit mask. While `ready` is low, address-0 command writes without bit 4 have no effect and produce no `eoi_vld`.
- R6: An address-0 command with bit 3 clear and bit 5 set is an end-of-interrupt. If bit 6 is set, it pulses `eoi_vld` with `eoi_pin` = data bits 2:0. If bit 6 is clear, it uses the external highest in-service pin, and produces no pulse when none is valid.
- R7: That same command loads `rotate_en` from bit 7. An end-of-interrupt that issues a clear while rotating makes the cleared pin the lowest priority. Without bit 5 but with bits 7 and 6 set, bits 2:0 load the lowest-priority pointer.
- R8: An address-0 command with bit 3 set loads `smm_en` from bit 5 only when bit 6 is set. When bit 1 is set, it loads `rd_isr_sel` from bit 0 and `poll_pend` from bit 2; otherwise both keep their value.
- R9: A read while `poll_pend` is high clears it. If an eligible pin exists, the read returns 0x80 OR the pin and pulses `ack_vld` with that pin. Otherwise it returns 0 with no acknowledge. With `aeoi_en` and `rotate_en` both set, the acknowledged pin becomes the lowest priority.
- R10: A read with no poll pending returns the mask at address 1. At address 0 it returns the in-service input when `rd_isr_sel` is 1, and the request input otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_a0 | input | 1 | Address bit |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high, 0 otherwise |
| irr_in | input | 8 | Request register from the sampling logic |
| isr_in | input | 8 | In-service register |
| elig_vld | input | 1 | External search found an eligible request |
| elig_pin | input | 3 | Highest eligible request pin |
| isr_top_vld | input | 1 | External search found an in-service pin |
| isr_top_pin | input | 3 | Highest in-service pin |
| ready | output | 1 | Initialization complete |
| vec_base | output | 5 | Vector base (upper five vector bits) |
| mask_o | output | 8 | Interrupt mask |
| aeoi_en | output | 1 | Auto end-of-interrupt enabled |
| sfn_en | output | 1 | Special fully nested mode |
| rotate_en | output | 1 | Rotation enabled |
| smm_en | output | 1 | Special mask mode |
| rd_isr_sel | output | 1 | Address-0 reads return the in-service register |
| poll_pend | output | 1 | Next read is a poll |
| lowprio | output | 3 | Lowest-priority pin pointer |
| eoi_vld | output | 1 | End-of-interrupt clear request strobe |
| eoi_pin | output | 3 | Pin whose in-service bit is to clear |
| irr_clr | output | 1 | Request register clear strobe |
| ack_vld | output | 1 | Poll acknowledge strobe |
| ack_pin | output | 3 | Acknowledged pin |
| init_err | output | 1 | Rejected initialization word strobe |

## Verification
The initialization sequence is driven three ways: complete, with a bad start word (single mode or missing step 4), and with a bad step 4. Comparing the mask, `ready` and `init_err` after each shows whether rejection really stops the sequence. End-of-interrupt commands are sent in specific form, in non-specific form with and without a valid in-service pin, and with rotation on and off. Watching `eoi_pin` and `lowprio` separates the specific path from the search path and separates rotation from plain clearing. Mode commands are sent with and without their enable bits (bit 6 for special mask, bit 1 for read select and poll). Poll reads are made with and without an eligible pin, and with auto end-of-interrupt plus rotation. Together these separate a gated field update from an unconditional one, and an acknowledging read from a plain register read.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;

  typedef enum logic [1:0] {
    STG_IDLE = 2'd0,
    STG_W2   = 2'd1,
    STG_W3   = 2'd2,
    STG_W4   = 2'd3
  } init_stage_e;

  // start-word fields
  localparam int I1_TAG    = 4;
  localparam int I1_SINGLE = 1;
  localparam int I1_NEED4  = 0;
  // step-4 fields
  localparam int I4_CPU    = 0;
  localparam int I4_AUTO   = 1;
  localparam int I4_NEST   = 4;
  // operation command discriminator
  localparam int OX_TAG    = 3;
  // end-of-interrupt / priority command fields
  localparam int O2_ROT    = 7;
  localparam int O2_SEL    = 6;
  localparam int O2_EOI    = 5;
  // mode command fields
  localparam int O3_ENMASK = 6;
  localparam int O3_MASK   = 5;
  localparam int O3_POLL   = 2;
  localparam int O3_RDREG  = 1;
  localparam int O3_RDISR  = 0;

endpackage

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_cmd_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int BASE_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd1_we,
  input  logic              cmd1_ok,
  input  logic              data_we,
  input  logic [BASE_W-1:0] base_in,
  input  logic              cpu_bit,
  input  logic              auto_bit,
  input  logic              nest_bit,
  output init_stage_e       stage_o,
  output logic              ready_o,
  output logic [BASE_W-1:0] base_o,
  output logic              aeoi_o,
  output logic              sfn_o,
  output logic              err_o
);

  init_stage_e stage_q;
  logic        ready_q;
  logic [BASE_W-1:0] base_q;
  logic        aeoi_q;
  logic        w4_we;
  logic        w4_good;

  assign w4_we   = data_we && (stage_q == STG_W4);
  assign w4_good = w4_we && cpu_bit;
  assign err_o   = (cmd1_we && !cmd1_ok) || (w4_we && !cpu_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_IDLE;
      ready_q <= 1'b0;
      base_q  <= '0;
      aeoi_q  <= 1'b0;
    end else if (cmd1_we) begin
      ready_q <= 1'b0;
      stage_q <= cmd1_ok ? STG_W2 : STG_IDLE;
    end else if (data_we) begin
      case (stage_q)
        STG_W2: begin
          base_q  <= base_in;
          stage_q <= STG_W3;
        end
        STG_W3: stage_q <= STG_W4;
        STG_W4: begin
          stage_q <= STG_IDLE;
          if (cpu_bit) begin
            aeoi_q  <= auto_bit;
            ready_q <= 1'b1;
          end
        end
        default: stage_q <= STG_IDLE;
      endcase
    end
  end

  generate
    if (IS_MASTER) begin : g_nest
      logic sfn_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sfn_q <= 1'b0;
        else if (w4_good) sfn_q <= nest_bit;
      end
      assign sfn_o = sfn_q;
    end else begin : g_no_nest
      assign sfn_o = 1'b0;
    end
  endgenerate

  assign stage_o = stage_q;
  assign ready_o = ready_q;
  assign base_o  = base_q;
  assign aeoi_o  = aeoi_q;

endmodule

// File: rtl/intc_op_dec.sv
module intc_op_dec
  import intc_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PIN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd1_we,
  input  logic              op_we,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              isr_top_vld,
  input  logic [PIN_W-1:0]  isr_top_pin,
  input  logic              poll_take,
  input  logic              ack_vld,
  input  logic [PIN_W-1:0]  ack_pin,
  input  logic              aeoi,
  output logic [DATA_W-1:0] mask_o,
  output logic              rotate_o,
  output logic              smm_o,
  output logic              rd_isr_o,
  output logic              poll_o,
  output logic [PIN_W-1:0]  lowprio_o,
  output logic              eoi_vld_o,
  output logic [PIN_W-1:0]  eoi_pin_o
);

  logic              prio_we;
  logic              mode_we;
  logic              eoi_req;
  logic [PIN_W-1:0]  eoi_pin_c;

  assign mode_we   = op_we &&  wdata[OX_TAG];
  assign prio_we   = op_we && !wdata[OX_TAG];
  assign eoi_req   = prio_we && wdata[O2_EOI];
  assign eoi_pin_c = wdata[O2_SEL] ? wdata[PIN_W-1:0] : isr_top_pin;
  assign eoi_vld_o = eoi_req && (wdata[O2_SEL] || isr_top_vld);
  assign eoi_pin_o = eoi_pin_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o    <= '0;
      rotate_o  <= 1'b0;
      smm_o     <= 1'b0;
      rd_isr_o  <= 1'b0;
      poll_o    <= 1'b0;
      lowprio_o <= '1;
    end else if (cmd1_we) begin
      mask_o    <= '0;
      smm_o     <= 1'b0;
      rd_isr_o  <= 1'b0;
      poll_o    <= 1'b0;
      lowprio_o <= '1;
    end else begin
      if (mask_we) mask_o <= wdata;
      if (prio_we) begin
        rotate_o <= wdata[O2_ROT];
        if (eoi_req) begin
          if (eoi_vld_o && wdata[O2_ROT]) lowprio_o <= eoi_pin_c;
        end else if (wdata[O2_SEL] && wdata[O2_ROT]) begin
          lowprio_o <= wdata[PIN_W-1:0];
        end
      end
      if (mode_we) begin
        if (wdata[O3_ENMASK]) smm_o <= wdata[O3_MASK];
        if (wdata[O3_RDREG]) begin
          rd_isr_o <= wdata[O3_RDISR];
          poll_o   <= wdata[O3_POLL];
        end
      end
      if (poll_take) poll_o <= 1'b0;
      if (ack_vld && aeoi && rotate_o) lowprio_o <= ack_pin;
    end
  end

endmodule

// File: rtl/intc_rd_path.sv
module intc_rd_path #(
  parameter int DATA_W = 8,
  parameter int PIN_W  = 3
) (
  input  logic              rd_go,
  input  logic              a0,
  input  logic              poll,
  input  logic              elig_vld,
  input  logic [PIN_W-1:0]  elig_pin,
  input  logic [DATA_W-1:0] mask,
  input  logic              rd_isr,
  input  logic [DATA_W-1:0] irr,
  input  logic [DATA_W-1:0] isr,
  output logic [DATA_W-1:0] rdata,
  output logic              poll_take,
  output logic              ack_vld,
  output logic [PIN_W-1:0]  ack_pin
);

  localparam int PAD_W = DATA_W - 1 - PIN_W;

  logic [DATA_W-1:0] poll_word;

  assign poll_take = rd_go && poll;
  assign ack_vld   = poll_take && elig_vld;
  assign ack_pin   = elig_pin;
  assign poll_word = elig_vld ? {1'b1, {PAD_W{1'b0}}, elig_pin} : '0;

  always_comb begin
    if (!rd_go)      rdata = '0;
    else if (poll)   rdata = poll_word;
    else if (a0)     rdata = mask;
    else if (rd_isr) rdata = isr;
    else             rdata = irr;
  end

endmodule

// File: rtl/intc_cmd_decoder.sv
module intc_cmd_decoder
  import intc_cmd_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int DATA_W    = 8,
  parameter int N_PINS    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_a0,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [N_PINS-1:0]           irr_in,
  input  logic [N_PINS-1:0]           isr_in,
  input  logic                        elig_vld,
  input  logic [$clog2(N_PINS)-1:0]   elig_pin,
  input  logic                        isr_top_vld,
  input  logic [$clog2(N_PINS)-1:0]   isr_top_pin,
  output logic                        ready,
  output logic [DATA_W-$clog2(N_PINS)-1:0] vec_base,
  output logic [N_PINS-1:0]           mask_o,
  output logic                        aeoi_en,
  output logic                        sfn_en,
  output logic                        rotate_en,
  output logic                        smm_en,
  output logic                        rd_isr_sel,
  output logic                        poll_pend,
  output logic [$clog2(N_PINS)-1:0]   lowprio,
  output logic                        eoi_vld,
  output logic [$clog2(N_PINS)-1:0]   eoi_pin,
  output logic                        irr_clr,
  output logic                        ack_vld,
  output logic [$clog2(N_PINS)-1:0]   ack_pin,
  output logic                        init_err
);

  localparam int PIN_W  = $clog2(N_PINS);
  localparam int BASE_W = DATA_W - PIN_W;

  init_stage_e stage_q;
  logic wr_cmd, cmd1_we, cmd1_ok, op_we, data_we, mask_we, rd_go, poll_take;

  assign wr_cmd  = bus_wr && !bus_a0;
  assign cmd1_we = wr_cmd && bus_wdata[I1_TAG];
  assign cmd1_ok = !bus_wdata[I1_SINGLE] && bus_wdata[I1_NEED4];
  assign op_we   = wr_cmd && !bus_wdata[I1_TAG] && ready;
  assign data_we = bus_wr && bus_a0 && (stage_q != STG_IDLE);
  assign mask_we = bus_wr && bus_a0 && ready && (stage_q == STG_IDLE);
  assign rd_go   = bus_rd && !bus_wr;
  assign irr_clr = cmd1_we;

  intc_init_seq #(
    .IS_MASTER(IS_MASTER),
    .BASE_W   (BASE_W)
  ) u_init (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd1_we  (cmd1_we),
    .cmd1_ok  (cmd1_ok),
    .data_we  (data_we),
    .base_in  (bus_wdata[DATA_W-1:PIN_W]),
    .cpu_bit  (bus_wdata[I4_CPU]),
    .auto_bit (bus_wdata[I4_AUTO]),
    .nest_bit (bus_wdata[I4_NEST]),
    .stage_o  (stage_q),
    .ready_o  (ready),
    .base_o   (vec_base),
    .aeoi_o   (aeoi_en),
    .sfn_o    (sfn_en),
    .err_o    (init_err)
  );

  intc_op_dec #(
    .DATA_W(DATA_W),
    .PIN_W (PIN_W)
  ) u_op (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd1_we    (cmd1_we),
    .op_we      (op_we),
    .mask_we    (mask_we),
    .wdata      (bus_wdata),
    .isr_top_vld(isr_top_vld),
    .isr_top_pin(isr_top_pin),
    .poll_take  (poll_take),
    .ack_vld    (ack_vld),
    .ack_pin    (ack_pin),
    .aeoi       (aeoi_en),
    .mask_o     (mask_o),
    .rotate_o   (rotate_en),
    .smm_o      (smm_en),
    .rd_isr_o   (rd_isr_sel),
    .poll_o     (poll_pend),
    .lowprio_o  (lowprio),
    .eoi_vld_o  (eoi_vld),
    .eoi_pin_o  (eoi_pin)
  );

  intc_rd_path #(
    .DATA_W(DATA_W),
    .PIN_W (PIN_W)
  ) u_rd (
    .rd_go    (rd_go),
    .a0       (bus_a0),
    .poll     (poll_pend),
    .elig_vld (elig_vld),
    .elig_pin (elig_pin),
    .mask     (mask_o),
    .rd_isr   (rd_isr_sel),
    .irr      (irr_in),
    .isr      (isr_in),
    .rdata    (bus_rdata),
    .poll_take(poll_take),
    .ack_vld  (ack_vld),
    .ack_pin  (ack_pin)
  );

endmodule

// File: rtl/intc_cmd_decoder_chk.sv
module intc_cmd_decoder_chk
  import intc_cmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_a0,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input init_stage_e stage_q,
  input logic        ready,
  input logic [4:0]  vec_base,
  input logic [7:0]  mask_o,
  input logic        smm_en,
  input logic        rd_isr_sel,
  input logic        poll_pend,
  input logic [2:0]  lowprio,
  input logic        eoi_vld,
  input logic        irr_clr,
  input logic        ack_vld,
  input logic [2:0]  ack_pin,
  input logic        init_err
);

  logic start_w;
  assign start_w = bus_wr && !bus_a0 && bus_wdata[4];

  p_start_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (mask_o == 8'h00 && lowprio == 3'd7 && !ready && !poll_pend && !smm_en && !rd_isr_sel));

  p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |-> irr_clr);

  p_start_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && (bus_wdata[1] || !bus_wdata[0])) |-> init_err);

  p_base_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_a0 && stage_q == STG_W2) |=> vec_base == $past(bus_wdata[7:3]));

  p_ready_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(bus_wr && bus_a0 && bus_wdata[0]));

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_a0 && ready) |=> mask_o == $past(bus_wdata));

  p_no_eoi_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !eoi_vld);

  p_eoi_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_vld |-> (bus_wr && !bus_a0 && bus_wdata[5] && !bus_wdata[3]));

  p_smm_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_a0 && ready && bus_wdata[3] && !bus_wdata[4] && !bus_wdata[6]) |=> $stable(smm_en));

  p_poll_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && poll_pend) |=> !poll_pend);

  p_ack_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> (bus_rdata == {5'b10000, ack_pin}));

endmodule

bind intc_cmd_decoder intc_cmd_decoder_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_a0    (bus_a0),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .stage_q   (stage_q),
  .ready     (ready),
  .vec_base  (vec_base),
  .mask_o    (mask_o),
  .smm_en    (smm_en),
  .rd_isr_sel(rd_isr_sel),
  .poll_pend (poll_pend),
  .lowprio   (lowprio),
  .eoi_vld   (eoi_vld),
  .irr_clr   (irr_clr),
  .ack_vld   (ack_vld),
  .ack_pin   (ack_pin),
  .init_err  (init_err)
);

// File: tb/test_intc_cmd_decoder.sv
module test_intc_cmd_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_a0 = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] irr_in = 8'h00, isr_in = 8'h00;
  logic       elig_vld = 1'b0, isr_top_vld = 1'b0;
  logic [2:0] elig_pin = 3'd0, isr_top_pin = 3'd0;
  logic       ready, aeoi_en, sfn_en, rotate_en, smm_en, rd_isr_sel, poll_pend;
  logic [4:0] vec_base;
  logic [7:0] mask_o;
  logic [2:0] lowprio, eoi_pin, ack_pin;
  logic       eoi_vld, irr_clr, ack_vld, init_err;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic       c_err, c_eoi, c_clr, c_ack;
  logic [2:0] c_eoi_pin, c_ack_pin;
  logic [7:0] c_rd;

  always #10 clk = ~clk;

  intc_cmd_decoder i_intc_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irr_in(irr_in), .isr_in(isr_in),
    .elig_vld(elig_vld), .elig_pin(elig_pin), .isr_top_vld(isr_top_vld),
    .isr_top_pin(isr_top_pin), .ready(ready), .vec_base(vec_base), .mask_o(mask_o),
    .aeoi_en(aeoi_en), .sfn_en(sfn_en), .rotate_en(rotate_en), .smm_en(smm_en),
    .rd_isr_sel(rd_isr_sel), .poll_pend(poll_pend), .lowprio(lowprio),
    .eoi_vld(eoi_vld), .eoi_pin(eoi_pin), .irr_clr(irr_clr), .ack_vld(ack_vld),
    .ack_pin(ack_pin), .init_err(init_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a0, input logic [7:0] d);
    @(negedge clk);
    bus_a0 = a0; bus_wdata = d; bus_wr = 1'b1;
    #5;
    c_err = init_err; c_eoi = eoi_vld; c_eoi_pin = eoi_pin; c_clr = irr_clr;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a0);
    @(negedge clk);
    bus_a0 = a0; bus_rd = 1'b1;
    #5;
    c_rd = bus_rdata; c_ack = ack_vld; c_ack_pin = ack_pin;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_init(input logic [7:0] w2, input logic [7:0] w4);
    wr(1'b0, 8'h11);
    wr(1'b1, w2);
    wr(1'b1, 8'h04);
    wr(1'b1, w4);
  endtask

  task automatic t_reset();
    chk("R1 reset ready", ready, 0);
    chk("R1 reset mask", mask_o, 0);
    chk("R1 reset lowprio", lowprio, 7);
    chk("R8 reset poll", poll_pend, 0);
  endtask

  task automatic t_init_ok();
    wr(1'b0, 8'h11);
    chk("R1 start irr_clr", c_clr, 1);
    chk("R2 start ok no err", c_err, 0);
    wr(1'b1, 8'h25);
    chk("R3 base", vec_base, 5'h04);
    wr(1'b1, 8'hFF);
    chk("R3 step3 no ready", ready, 0);
    chk("R3 step3 base kept", vec_base, 5'h04);
    wr(1'b1, 8'h03);
    chk("R4 ready", ready, 1);
    chk("R4 aeoi", aeoi_en, 1);
    chk("R4 sfn off", sfn_en, 0);
  endtask

  task automatic t_init_reject();
    wr(1'b0, 8'h13);
    chk("R2 single rejected err", c_err, 1);
    chk("R1 ready dropped", ready, 0);
    wr(1'b1, 8'h55);
    chk("R2 no sequence mask", mask_o, 0);
    chk("R2 no sequence ready", ready, 0);
    wr(1'b0, 8'h10);
    chk("R2 missing step4 err", c_err, 1);
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    chk("R4 cpu bit err", c_err, 1);
    chk("R4 not ready", ready, 0);
    isr_top_vld = 1'b1; isr_top_pin = 3'd2;
    wr(1'b0, 8'h20);
    chk("R5 early eoi ignored", c_eoi, 0);
    isr_top_vld = 1'b0;
  endtask

  task automatic t_mask();
    do_init(8'h40, 8'h11);
    chk("R4 sfn master", sfn_en, 1);
    chk("R4 aeoi off", aeoi_en, 0);
    chk("R3 base 2", vec_base, 5'h08);
    wr(1'b1, 8'hA5);
    chk("R5 mask", mask_o, 8'hA5);
    rd(1'b1);
    chk("R10 read mask", c_rd, 8'hA5);
    wr(1'b0, 8'h11);
    chk("R1 mask cleared", mask_o, 0);
  endtask

  task automatic t_eoi();
    do_init(8'h08, 8'h01);
    isr_top_vld = 1'b1; isr_top_pin = 3'd5;
    wr(1'b0, 8'h20);
    chk("R6 nonspecific vld", c_eoi, 1);
    chk("R6 nonspecific pin", c_eoi_pin, 5);
    chk("R7 no rotate lowprio", lowprio, 7);
    wr(1'b0, 8'h63);
    chk("R6 specific vld", c_eoi, 1);
    chk("R6 specific pin", c_eoi_pin, 3);
    isr_top_vld = 1'b0;
    wr(1'b0, 8'h20);
    chk("R6 none in service", c_eoi, 0);
    isr_top_vld = 1'b1; isr_top_pin = 3'd6;
    wr(1'b0, 8'hA0);
    chk("R6 rotate eoi pin", c_eoi_pin, 6);
    chk("R7 rotate on", rotate_en, 1);
    chk("R7 rotate lowprio", lowprio, 6);
    wr(1'b0, 8'hC2);
    chk("R7 set priority no eoi", c_eoi, 0);
    chk("R7 set priority", lowprio, 2);
    wr(1'b0, 8'h44);
    chk("R7 rotate off", rotate_en, 0);
    chk("R7 lowprio kept", lowprio, 2);
    isr_top_vld = 1'b0;
  endtask

  task automatic t_mode();
    wr(1'b0, 8'h68);
    chk("R8 smm on", smm_en, 1);
    wr(1'b0, 8'h48);
    chk("R8 smm off", smm_en, 0);
    wr(1'b0, 8'h28);
    chk("R8 smm gated", smm_en, 0);
    irr_in = 8'h12; isr_in = 8'h40;
    wr(1'b0, 8'h0B);
    rd(1'b0);
    chk("R10 read isr", c_rd, 8'h40);
    wr(1'b0, 8'h0A);
    rd(1'b0);
    chk("R10 read irr", c_rd, 8'h12);
    wr(1'b0, 8'h09);
    chk("R8 select gated", rd_isr_sel, 0);
  endtask

  task automatic t_poll();
    wr(1'b0, 8'h0C);
    chk("R8 poll gated", poll_pend, 0);
    wr(1'b0, 8'h0E);
    chk("R8 poll set", poll_pend, 1);
    elig_vld = 1'b1; elig_pin = 3'd4;
    rd(1'b1);
    chk("R9 poll word", c_rd, 8'h84);
    chk("R9 ack", c_ack, 1);
    chk("R9 ack pin", c_ack_pin, 4);
    chk("R9 poll cleared", poll_pend, 0);
    rd(1'b0);
    chk("R9 plain read after poll", c_rd, 8'h12);
    chk("R9 no ack plain", c_ack, 0);
    wr(1'b0, 8'h0E);
    elig_vld = 1'b0;
    rd(1'b0);
    chk("R9 empty poll", c_rd, 8'h00);
    chk("R9 empty no ack", c_ack, 0);
    chk("R9 empty cleared", poll_pend, 0);
    do_init(8'h08, 8'h03);
    wr(1'b0, 8'h80);
    chk("R7 rotate only", lowprio, 7);
    wr(1'b0, 8'h0E);
    elig_vld = 1'b1; elig_pin = 3'd3;
    rd(1'b0);
    chk("R9 auto rotate lowprio", lowprio, 3);
    elig_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_ok();
    t_init_reject();
    t_mask();
    t_eoi();
    t_mode();
    t_poll();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule